// File: doc/BRIEF.md
# Sigma-Delta Serial Bitstream Receiver

This block is the front end of a multi-channel sigma-delta acquisition path. Each of its lanes takes a 1-bit modulator stream from one serial input (a data pin and a clock pin). For every decoded bit it emits that bit together with a one-cycle valid strobe. Decimation happens downstream and is not part of this block.

Each lane is configured on its own. A lane can run as a clocked serial receiver that samples on the rising or the falling edge of its chosen clock. It can instead run as a Manchester decoder with either polarity convention. A clocked lane picks its clock from four sources:
- its own external clock pin;
- a clock output that the block generates from a programmable divider;
- that generated clock halved by a divider that advances on its falling edges;
- that generated clock halved by a divider that advances on its rising edges.

A lane can also read the neighbouring input instead of its own. Two modulators that share one data/clock pair can then be split across two lanes, one on each edge.

All pins pass through two synchronizing flops. Edges are found by comparing levels in the single system clock domain, so that clock must run at least four times faster than any serial clock. Each lane also watches for activity and raises a flag when its clock (or, in Manchester mode, its data) stops moving for longer than a programmed number of system clocks.

Top module: `sdrx_top`

## Requirements
- R1: `ck_out` is forced low and the divider restarts while `en` is low. With `en` high, `ck_out` toggles every `cfg_div`+1 system clocks, so its period is 2·(`cfg_div`+1). The first toggle comes on the (`cfg_div`+1)-th enabled clock edge.
- R2: A lane with type code 0 (clocked, rising edge) and source code 1 (its external clock pin) pulses `smp_vld` for one cycle per rising clock edge. If a pin change is first sampled at system edge k, `smp_vld` is high after edge k+2. `smp_bit` carries the data pin as sampled at edge k.
- R3: Type code 1 (clocked, falling edge) behaves like R2 but reacts to falling edges of the selected clock.
- R4: Type code 2 is Manchester decoding in which a mid-bit transition to 1 decodes as 0 and a transition to 0 decodes as 1. A data transition first sampled at edge k gives the pulse after edge k+2.
- R5: Type code 3 is Manchester decoding with the opposite sense: a transition to 1 decodes as 1 and a transition to 0 decodes as 0.
- R6: In Manchester mode, a data transition is accepted as mid-bit only when at least P − floor(P/4) system clocks have passed since the previous accepted one, where P is `cfg_bitper`. Earlier transitions produce no pulse. After `en` rises, the first transition is always accepted.
- R7: Source code 0 clocks a lane from the generated `ck_out`.
- R8: Source code 2 clocks a lane from a half-rate clock that toggles on each falling edge of `ck_out`. Source code 3 uses one that toggles on each rising edge of `ck_out`. Both are low while disabled.
- R9: With `cfg_alt[n]` clear, lane n reads data pin n and clock pin n. With it set, lane n reads pin (n+1) mod NCH, so the last lane wraps to pin 0.
- R10: `ck_lost[n]` is high while the count of system clocks since the lane's last activity is at least `cfg_tmo`. Activity is any edge of the selected clock in clocked modes, or any data transition in Manchester mode. The count saturates at its maximum.
- R11: While `en` is low, no `smp_vld` pulse occurs, the activity counts are cleared and the Manchester spacing state is reset.
- R12: `smp_bit[n]` changes only together with a `smp_vld[n]` pulse and holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| cfg_div | input | DIVW | Generated clock half period minus one |
| cfg_bitper | input | BPW | Manchester nominal bit period in system clocks |
| cfg_tmo | input | TOW | Activity timeout in system clocks |
| cfg_type | input | 2·NCH | Per-lane decode type, 2 bits per lane |
| cfg_src | input | 2·NCH | Per-lane clock source, 2 bits per lane |
| cfg_alt | input | NCH | Per-lane neighbour-input select |
| sd_dat | input | NCH | Serial data pins |
| sd_ck | input | NCH | External serial clock pins |
| ck_out | output | 1 | Generated serial clock |
| smp_bit | output | NCH | Decoded bit per lane |
| smp_vld | output | NCH | One-cycle strobe per decoded bit |
| ck_lost | output | NCH | Per-lane activity timeout flag |

## Verification
All eight lanes run at the same time with different settings:
- two lanes on one shared pin pair, one on each edge, which separates rising-edge from falling-edge capture and proves the neighbour mapping;
- two Manchester lanes of opposite polarity, fed with glitches placed inside the guard window, which separates accepted mid-bit transitions from ignored boundary or glitch transitions;
- lanes clocked from the generated clock and from both half-rate clocks, which show whether the half-rate dividers advance on the correct edge of `ck_out`.

Partway through, a clock pin and a Manchester pin are stopped to raise the activity flags. The block is then disabled and re-enabled with a different divider and with types and sources swapped between lanes.

// File: rtl/sdrx_pkg.sv
`timescale 1ns/1ps
package sdrx_pkg;

  typedef enum logic [1:0] {
    TY_SER_RISE  = 2'd0,
    TY_SER_FALL  = 2'd1,
    TY_MAN_RISE0 = 2'd2,
    TY_MAN_RISE1 = 2'd3
  } lane_type_e;

  typedef enum logic [1:0] {
    SRC_INT    = 2'd0,
    SRC_EXT    = 2'd1,
    SRC_HALF_F = 2'd2,
    SRC_HALF_R = 2'd3
  } lane_src_e;

  typedef struct packed {
    logic ck;
    logic half_f;
    logic half_r;
  } intclk_t;

  // earliest spacing, in system clocks, at which a transition counts as mid-bit
  function automatic logic [31:0] mid_gate(input logic [31:0] per);
    return per - (per >> 2);
  endfunction

  // pin read by a lane when its neighbour mapping is set
  function automatic int nbr(input int lane, input int n);
    return (lane + 1) % n;
  endfunction

endpackage

// File: rtl/sdrx_sync.sv
`timescale 1ns/1ps
module sdrx_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/sdrx_clkgen.sv
`timescale 1ns/1ps
module sdrx_clkgen
  import sdrx_pkg::*;
#(
  parameter int DIVW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [DIVW-1:0] cfg_div,
  output intclk_t         ic
);
  logic [DIVW-1:0] cnt;
  logic            wrap;
  logic            rise_ev;
  logic            fall_ev;

  assign wrap    = (cnt >= cfg_div);
  assign rise_ev = en & wrap & ~ic.ck;
  assign fall_ev = en & wrap &  ic.ck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ic  <= '0;
    end else if (!en) begin
      cnt <= '0;
      ic  <= '0;
    end else if (wrap) begin
      cnt   <= '0;
      ic.ck <= ~ic.ck;
      if (rise_ev) ic.half_r <= ~ic.half_r;
      if (fall_ev) ic.half_f <= ~ic.half_f;
    end else begin
      cnt <= cnt + DIVW'(1);
    end
  end
endmodule

// File: rtl/sdrx_lane.sv
`timescale 1ns/1ps
module sdrx_lane
  import sdrx_pkg::*;
#(
  parameter int BPW = 10,
  parameter int TOW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  lane_type_e     ty,
  input  lane_src_e      src,
  input  logic [BPW-1:0] bitper,
  input  logic [TOW-1:0] tmo,
  input  logic           dat,
  input  logic           ck_ext,
  input  intclk_t        ic,
  output logic           smp,
  output logic           vld,
  output logic           lost,
  output logic           act
);
  localparam logic [BPW-1:0] SMAX = '1;
  localparam logic [TOW-1:0] IMAX = '1;

  logic           lvl, lvl_q, dat_q;
  logic           is_man, edge_hit, trans, take, man_val;
  logic [31:0]    gate;
  logic [BPW-1:0] since;
  logic [TOW-1:0] idle;

  always_comb begin
    unique case (src)
      SRC_INT:    lvl = ic.ck;
      SRC_EXT:    lvl = ck_ext;
      SRC_HALF_F: lvl = ic.half_f;
      default:    lvl = ic.half_r;
    endcase
  end

  assign is_man   = (ty == TY_MAN_RISE0) || (ty == TY_MAN_RISE1);
  assign edge_hit = (ty == TY_SER_RISE) ? (lvl & ~lvl_q) : (~lvl & lvl_q);
  assign trans    = dat ^ dat_q;
  assign gate     = mid_gate(32'(bitper));
  assign take     = is_man && trans && (32'(since) >= gate);
  assign man_val  = (ty == TY_MAN_RISE1) ? dat : ~dat;
  assign act      = is_man ? trans : (lvl ^ lvl_q);
  assign lost     = (idle >= tmo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      dat_q <= 1'b0;
      smp   <= 1'b0;
      vld   <= 1'b0;
      since <= SMAX;
      idle  <= '0;
    end else begin
      lvl_q <= lvl;
      dat_q <= dat;
      if (!en) begin
        vld   <= 1'b0;
        since <= SMAX;
        idle  <= '0;
      end else begin
        if (is_man) begin
          vld <= take;
          if (take) smp <= man_val;
        end else begin
          vld <= edge_hit;
          if (edge_hit) smp <= dat;
        end
        if (take)               since <= '0;
        else if (since != SMAX) since <= since + BPW'(1);
        if (act)                idle <= '0;
        else if (idle != IMAX)  idle <= idle + TOW'(1);
      end
    end
  end
endmodule

// File: rtl/sdrx_top.sv
`timescale 1ns/1ps
module sdrx_top
  import sdrx_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int DIVW = 7,
  parameter int BPW  = 10,
  parameter int TOW  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DIVW-1:0]   cfg_div,
  input  logic [BPW-1:0]    cfg_bitper,
  input  logic [TOW-1:0]    cfg_tmo,
  input  logic [2*NCH-1:0]  cfg_type,
  input  logic [2*NCH-1:0]  cfg_src,
  input  logic [NCH-1:0]    cfg_alt,
  input  logic [NCH-1:0]    sd_dat,
  input  logic [NCH-1:0]    sd_ck,
  output logic              ck_out,
  output logic [NCH-1:0]    smp_bit,
  output logic [NCH-1:0]    smp_vld,
  output logic [NCH-1:0]    ck_lost
);
  logic [NCH-1:0] dat_s, ck_s;
  logic [NCH-1:0] lane_dat, lane_ck, lane_act;
  intclk_t        ic;

  sdrx_sync #(.W(2*NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sd_ck, sd_dat}), .q({ck_s, dat_s})
  );

  sdrx_clkgen #(.DIVW(DIVW)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_div(cfg_div), .ic(ic)
  );

  assign ck_out = ic.ck;

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    localparam int NB = nbr(i, NCH);
    assign lane_dat[i] = cfg_alt[i] ? dat_s[NB] : dat_s[i];
    assign lane_ck[i]  = cfg_alt[i] ? ck_s[NB]  : ck_s[i];

    sdrx_lane #(.BPW(BPW), .TOW(TOW)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .ty     (lane_type_e'(cfg_type[2*i +: 2])),
      .src    (lane_src_e'(cfg_src[2*i +: 2])),
      .bitper (cfg_bitper),
      .tmo    (cfg_tmo),
      .dat    (lane_dat[i]),
      .ck_ext (lane_ck[i]),
      .ic     (ic),
      .smp    (smp_bit[i]),
      .vld    (smp_vld[i]),
      .lost   (ck_lost[i]),
      .act    (lane_act[i])
    );
  end
endmodule

// File: rtl/sdrx_checker.sv
`timescale 1ns/1ps
module sdrx_checker #(
  parameter int NCH  = 8,
  parameter int DIVW = 7,
  parameter int BPW  = 10,
  parameter int TOW  = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic [DIVW-1:0] cfg_div,
  input logic [BPW-1:0]  cfg_bitper,
  input logic [TOW-1:0]  cfg_tmo,
  input logic            ck_out,
  input logic [NCH-1:0]  smp_vld,
  input logic [NCH-1:0]  ck_lost,
  input logic [NCH-1:0]  lane_act
);
  assert_clkout_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !ck_out);

  assert_clkout_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en && (cfg_div == '0) |=> (ck_out != $past(ck_out)));

  assert_clkout_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ck_out) && en && (cfg_div != '0) |=> ck_out);

  assert_no_strobe_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (smp_vld == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_bitper >= BPW'(4)) && smp_vld[i] |=> !smp_vld[i]);

    assert_activity_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      en && lane_act[i] && (cfg_tmo != '0) |=> (!ck_lost[i] || cfg_tmo == '0));
  end
endmodule

bind sdrx_top sdrx_checker #(.NCH(NCH), .DIVW(DIVW), .BPW(BPW), .TOW(TOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cfg_div(cfg_div), .cfg_bitper(cfg_bitper),
  .cfg_tmo(cfg_tmo), .ck_out(ck_out), .smp_vld(smp_vld), .ck_lost(ck_lost),
  .lane_act(lane_act)
);

// File: tb/sdrx_top_test.sv
`timescale 1ns/1ps
module sdrx_top_test;
  localparam int NCH = 8, DIVW = 7, BPW = 10, TOW = 10;
  localparam int SAT = 1023;
  localparam int MPER = 16;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [DIVW-1:0]  cfg_div = '0;
  logic [BPW-1:0]   cfg_bitper = '0;
  logic [TOW-1:0]   cfg_tmo = '0;
  logic [2*NCH-1:0] cfg_type = '0, cfg_src = '0;
  logic [NCH-1:0]   cfg_alt = '0, sd_dat = '0, sd_ck = '0;
  logic             ck_out;
  logic [NCH-1:0]   smp_bit, smp_vld, ck_lost;

  always #2 clk = ~clk;

  sdrx_top #(.NCH(NCH), .DIVW(DIVW), .BPW(BPW), .TOW(TOW)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_div(cfg_div), .cfg_bitper(cfg_bitper),
    .cfg_tmo(cfg_tmo), .cfg_type(cfg_type), .cfg_src(cfg_src), .cfg_alt(cfg_alt),
    .sd_dat(sd_dat), .sd_ck(sd_ck), .ck_out(ck_out), .smp_bit(smp_bit),
    .smp_vld(smp_vld), .ck_lost(ck_lost)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // ---------------- behavioural reference ----------------
  logic [NCH-1:0] hd[4] = '{default: '0};
  logic [NCH-1:0] hc[4] = '{default: '0};
  logic m_lq[NCH] = '{default: 1'b0};
  logic m_dq[NCH] = '{default: 1'b0};
  logic m_smp[NCH] = '{default: 1'b0};
  logic m_vld[NCH] = '{default: 1'b0};
  int   m_since[NCH] = '{default: SAT};
  int   m_idle[NCH] = '{default: 0};
  logic ic_ck = 1'b0, ic_hf = 1'b0, ic_hr = 1'b0;
  int   u = 0, e_start = -1;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin hd[k] = '0; hc[k] = '0; end
      for (int i = 0; i < NCH; i++) begin
        m_lq[i] = 0; m_dq[i] = 0; m_smp[i] = 0; m_vld[i] = 0;
        m_since[i] = SAT; m_idle[i] = 0;
      end
      ic_ck = 0; ic_hf = 0; ic_hr = 0; e_start = -1;
    end else begin
      u++;
      for (int k = 3; k > 0; k--) begin hd[k] = hd[k-1]; hc[k] = hc[k-1]; end
      hd[0] = sd_dat; hc[0] = sd_ck;
      for (int i = 0; i < NCH; i++) begin
        int p, ty, sr, per;
        logic d, lv, tr, tk, hit, act;
        p  = cfg_alt[i] ? (i + 1) % NCH : i;
        ty = int'(cfg_type[2*i +: 2]);
        sr = int'(cfg_src[2*i +: 2]);
        per = int'(cfg_bitper);
        d  = hd[2][p];
        case (sr)
          0: lv = ic_ck;
          1: lv = hc[2][p];
          2: lv = ic_hf;
          default: lv = ic_hr;
        endcase
        tr = (d != m_dq[i]);
        if (!en) begin
          m_vld[i] = 0; m_since[i] = SAT; m_idle[i] = 0;
        end else begin
          tk = 0;
          if (ty >= 2) begin
            tk = tr && (m_since[i] >= per - per / 4);
            m_vld[i] = tk;
            if (tk) m_smp[i] = (ty == 3) ? d : !d;
            act = tr;
          end else begin
            hit = (ty == 0) ? (lv && !m_lq[i]) : (!lv && m_lq[i]);
            m_vld[i] = hit;
            if (hit) m_smp[i] = d;
            act = (lv != m_lq[i]);
          end
          m_since[i] = tk ? 0 : (m_since[i] < SAT ? m_since[i] + 1 : SAT);
          m_idle[i]  = act ? 0 : (m_idle[i] < SAT ? m_idle[i] + 1 : SAT);
        end
        m_lq[i] = lv; m_dq[i] = d;
      end
      if (!en) begin
        ic_ck = 0; ic_hf = 0; ic_hr = 0; e_start = -1;
      end else begin
        int t;
        if (e_start < 0) e_start = u;
        t = (u - e_start + 1) / (int'(cfg_div) + 1);
        ic_ck = t[0];
        ic_hr = ((t + 1) / 2) % 2;
        ic_hf = (t / 2) % 2;
      end
    end
  end

  // ---------------- compare ----------------
  function automatic string lane_tag(int i);
    int ty, sr;
    string s;
    if (!en) return "R11";
    ty = int'(cfg_type[2*i +: 2]);
    sr = int'(cfg_src[2*i +: 2]);
    if (ty == 2)      s = "R4/R6";
    else if (ty == 3) s = "R5/R6";
    else if (sr == 0) s = "R7";
    else if (sr == 1) s = (ty == 0) ? "R2" : "R3";
    else              s = "R8";
    if (cfg_alt[i]) s = {s, " R9"};
    return s;
  endfunction

  task automatic chk(input string tag, input string what, input int i,
                     input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s ch%0d %s at cycle %0d: got %b expected %b", tag, i, what, u, got, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1", "ck_out", 0, ck_out, ic_ck);
    for (int i = 0; i < NCH; i++) begin
      chk(lane_tag(i), "smp_vld", i, smp_vld[i], m_vld[i]);
      chk(m_vld[i] ? lane_tag(i) : "R12", "smp_bit", i, smp_bit[i], m_smp[i]);
      chk("R10", "ck_lost", i, ck_lost[i], logic'(m_idle[i] >= int'(cfg_tmo)));
    end
  endtask

  // ---------------- stimulus ----------------
  int   ck_ph = 0, mph = 0;
  logic run_ext0 = 1'b1, run_man3 = 1'b1;
  logic mb3 = 1'b0, mb4 = 1'b0, glitch = 1'b0;
  logic [NCH-1:0] ckv = '0;

  task automatic drive_pins();
    logic [NCH-1:0] d;
    d = NCH'($urandom);
    ck_ph = (ck_ph + 1) % 8;
    if (ck_ph == 0) ckv = ~ckv;
    if (mph == 0) begin
      mb3 = 1'($urandom); mb4 = 1'($urandom); glitch = ($urandom % 4) == 0;
    end
    d[3] = run_man3 ? ((mph < MPER / 2) ? mb3 : ~mb3) : 1'b0;
    if (run_man3 && glitch && (mph == 11 || mph == 12)) d[3] = ~d[3];
    d[4] = (mph < MPER / 2) ? ~mb4 : mb4;
    mph = (mph + 1) % MPER;
    sd_dat = d;
    sd_ck = '0;
    sd_ck[0] = run_ext0 ? ckv[0] : 1'b0;
    sd_ck[1] = ckv[1];
    sd_ck[2] = ckv[2];
  endtask

  task automatic step(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare_all();
      drive_pins();
    end
  endtask

  function automatic logic [2*NCH-1:0] pack2(input int v[NCH]);
    logic [2*NCH-1:0] r;
    for (int i = 0; i < NCH; i++) r[2*i +: 2] = 2'(v[i]);
    return r;
  endfunction

  initial begin
    cfg_div = 7'd2; cfg_bitper = BPW'(MPER); cfg_tmo = TOW'(40);
    // lanes: 0 ext rise, 1 ext fall on pin2, 2 ext rise on pin2, 3/4 Manchester,
    // 5 internal rise, 6 half-falling fall, 7 half-rising rise on pin0
    cfg_type = pack2('{0, 1, 0, 2, 3, 0, 1, 0});
    cfg_src  = pack2('{1, 1, 1, 0, 0, 0, 2, 3});
    cfg_alt  = 8'b1000_0010;
    step(6);                       // reset state, R11 tags while disabled
    rst_n = 1'b1;
    step(4);
    en = 1'b1;
    step(2000);                    // main traffic
    run_ext0 = 1'b0; run_man3 = 1'b0;
    step(500);                     // R10: lanes 0 and 3 go silent
    en = 1'b0;
    step(20);
    cfg_div  = 7'd0;
    cfg_type = pack2('{1, 0, 1, 2, 3, 0, 0, 1});
    cfg_src  = pack2('{1, 1, 1, 0, 0, 2, 0, 3});
    run_ext0 = 1'b1; run_man3 = 1'b1;
    step(20);
    en = 1'b1;
    step(1500);
    en = 1'b0;
    step(20);
    cfg_div  = 7'd5;
    cfg_tmo  = TOW'(25);
    cfg_type = pack2('{0, 0, 1, 3, 2, 1, 0, 1});
    cfg_src  = pack2('{3, 1, 1, 0, 0, 2, 3, 1});
    cfg_alt  = 8'b1000_0001;
    step(20);
    en = 1'b1;
    step(1500);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule